// File: doc/BRIEF.md
# Privilege and feature mode flag generator

This block turns the processor's status and configuration registers, plus a set of straps that describe which instruction-set levels and extensions the core implements, into a registered vector of execution-mode flags. Downstream logic reads the flags instead of re-decoding the raw registers: the effective privilege level, coprocessor 0 and 1 access, 64-bit FPU register mode, DSP, SIMD and FPU-emulation enables, read-inhibit for non-kernel modes, and extended physical addressing with its physical address mask.

Most flags are not copies of one register bit. Each one is gated by a mix of the effective privilege level, the implementation straps and configuration bits. The flags are registered: a change on any source is visible on the outputs one clock edge later. Instruction decode, TLB flushing and 64-bit address-wrap rules are handled elsewhere. The 64-bit execution indicator arrives as an input.

Top module: `mode_flag_gen`

## Requirements
- R1: The effective privilege `ksu_o` equals `status_i[4:3]` when `status_i[1]` (exception level), `status_i[2]` (error level) and `debug_mode_i` are all 0. Otherwise it is forced to 2'b00. The encodings are 2'b00 kernel, 2'b01 supervisor and 2'b10 user; 2'b11 passes through unchanged.
- R2: `cp0_ok_o` is 1 when the effective privilege is kernel, or when `status_i[28]` is 1 and `isa_r6_i` is 0. Otherwise it is 0.
- R3: `fpu_ok_o` follows `status_i[29]` and `fpu64_o` follows `status_i[26]`.
- R4: `rinh_o` is 1 only when the effective privilege is not kernel and `cfg5_i[6]` is 1.
- R5: When `has_dspr2_i` is 1, `status_i[24]` drives both `dsp_o` and `dsp2_o`. When only `has_dsp_i` is 1, `status_i[24]` drives `dsp_o` and `dsp2_o` stays 0. When neither strap is set, both outputs are 0.
- R6: `cop1x_o` is selected by the first strap set, in this priority: `isa_r2_i` selects `fpu_impl_i[22]`, then `isa_m32_i` selects `mode64_i`, then `isa_m4_i` selects `status_i[31]`. With none of them set, `cop1x_o` is 0.
- R7: `msa_o` is 1 exactly when `has_msa_i` is 1 and `cfg5_i[27]` is 1.
- R8: `fre_o` is 1 exactly when `fpu_impl_i[29]` is 1 and `cfg5_i[8]` is 1.
- R9: `elpa_o` is 1 exactly when `cfg3_i[7]` and `pgrain_i[29]` are both 1. `pa_mask_o` is all ones over `PA_BITS` bits when `elpa_o` is 1. Otherwise it has only its low 32 bits set.
- R10: Every output reflects the inputs sampled at the previous rising clock edge. An input change does not reach the outputs before that edge.
- R11: Reset is synchronous and active low. While it is applied, `ksu_o` is kernel (2'b00), `cp0_ok_o` is 1, every other flag is 0 and `pa_mask_o` has only its low 32 bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| status_i | input | 32 | Status register |
| cfg3_i | input | 32 | Third configuration register |
| cfg5_i | input | 32 | Fifth configuration register |
| pgrain_i | input | 32 | Page-granularity register |
| fpu_impl_i | input | 32 | FPU implementation register |
| debug_mode_i | input | 1 | Core is in debug mode |
| mode64_i | input | 1 | 64-bit execution indicator |
| isa_r6_i | input | 1 | Strap: release-6 mode |
| isa_r2_i | input | 1 | Strap: release-2 mode |
| isa_m32_i | input | 1 | Strap: 32-bit base ISA mode |
| isa_m4_i | input | 1 | Strap: fourth-generation ISA mode |
| has_dsp_i | input | 1 | Strap: base DSP implemented |
| has_dspr2_i | input | 1 | Strap: DSP revision 2 implemented |
| has_msa_i | input | 1 | Strap: SIMD extension implemented |
| ksu_o | output | 2 | Effective privilege level |
| cp0_ok_o | output | 1 | Coprocessor 0 access |
| fpu_ok_o | output | 1 | FPU usable |
| fpu64_o | output | 1 | 64-bit FPU registers |
| rinh_o | output | 1 | Read-inhibit enable |
| dsp_o | output | 1 | DSP enable |
| dsp2_o | output | 1 | DSP revision 2 enable |
| cop1x_o | output | 1 | Paired/extended FP op enable |
| msa_o | output | 1 | SIMD enable |
| fre_o | output | 1 | FPU-emulation mode enable |
| elpa_o | output | 1 | Extended physical addressing |
| pa_mask_o | output | PA_BITS | Physical address mask |

## Verification
The directed patterns cover each way into forced kernel mode (exception level, error level, debug) against plain user and supervisor settings. They also walk each strap priority level for the paired-FP flag and each DSP strap combination. These show whether each gate selects the right source instead of copying one bit. Release-6 against non-release-6 with the coprocessor-0 bit set shows whether the strap can withdraw access. Several hundred random register and strap combinations, compared against an independent model, catch interactions the directed cases miss. A reset applied mid-run and a same-cycle output check confirm the reset values and the one-edge latency.

// File: rtl/mfg_pkg.sv
// Shared types and fixed bit positions for the mode flag generator.
// Assumes 32-bit source registers. The bit positions are architectural.
package mfg_pkg;
    typedef enum logic [1:0] {
        PRIV_KERN = 2'b00,
        PRIV_SUP  = 2'b01,
        PRIV_USER = 2'b10,
        PRIV_RSVD = 2'b11
    } priv_t;

    typedef struct packed {
        priv_t ksu;
        logic  cp0_ok;
        logic  fpu_ok;
        logic  fpu64;
        logic  rinh;
        logic  dsp;
        logic  dsp2;
        logic  cop1x;
        logic  msa;
        logic  fre;
        logic  elpa;
    } mode_flags_t;

    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_KSU   = 3;
    localparam int ST_MX    = 24;
    localparam int ST_FR    = 26;
    localparam int ST_CU0   = 28;
    localparam int ST_CU1   = 29;
    localparam int ST_CU3   = 31;
    localparam int C3_LPA   = 7;
    localparam int C5_SBRI  = 6;
    localparam int C5_FRE   = 8;
    localparam int C5_MSAEN = 27;
    localparam int PG_ELPA  = 29;
    localparam int FI_F64   = 22;
    localparam int FI_FREP  = 29;

    // Flag values held while reset is applied: kernel, with CP0 access.
    localparam mode_flags_t FLAGS_RESET = '{ksu: PRIV_KERN, cp0_ok: 1'b1, default: 1'b0};
endpackage

// File: rtl/mfg_priv.sv
// Privilege decode: works out the effective privilege level and the
// flags that depend on it. Combinational; the caller registers the result.
module mfg_priv
    import mfg_pkg::*;
(
    input  logic [1:0] ksu_raw,
    input  logic       exl,
    input  logic       erl,
    input  logic       dbg,
    input  logic       cu0,
    input  logic       isa_r6,
    input  logic       sbri_en,
    output priv_t      ksu,
    output logic       cp0_ok,
    output logic       rinh
);
    logic forced_kernel;

    // Any exception, error or debug state pins the core to kernel.
    always_comb forced_kernel = exl | erl | dbg;

    // Effective privilege and the flags that depend on it.
    always_comb begin
        ksu    = forced_kernel ? PRIV_KERN : priv_t'(ksu_raw);
        cp0_ok = (ksu == PRIV_KERN) | (cu0 & ~isa_r6);
        rinh   = (ksu != PRIV_KERN) & sbri_en;
    end
endmodule

// File: rtl/mfg_feat.sv
// Feature decode: works out the coprocessor-1, DSP, SIMD, FPU-emulation
// and extended-addressing enables from register bits and straps.
// Combinational; no dependence on privilege.
module mfg_feat (
    input  logic cu1,
    input  logic fr,
    input  logic mx,
    input  logic cu3,
    input  logic f64_impl,
    input  logic frep_impl,
    input  logic msa_en,
    input  logic fre_en,
    input  logic lpa_impl,
    input  logic elpa_en,
    input  logic mode64,
    input  logic isa_r2,
    input  logic isa_m32,
    input  logic isa_m4,
    input  logic has_dsp,
    input  logic has_dspr2,
    input  logic has_msa,
    output logic fpu_ok,
    output logic fpu64,
    output logic dsp,
    output logic dsp2,
    output logic cop1x,
    output logic msa,
    output logic fre,
    output logic elpa
);
    // Coprocessor-1 and DSP enables.
    always_comb begin
        fpu_ok = cu1;
        fpu64  = fr;
        dsp    = (has_dspr2 | has_dsp) & mx;
        dsp2   = has_dspr2 & mx;
    end

    // Paired/extended FP enable, chosen by the first matching ISA strap.
    always_comb begin
        if (isa_r2)       cop1x = f64_impl;
        else if (isa_m32) cop1x = mode64;
        else if (isa_m4)  cop1x = cu3;
        else              cop1x = 1'b0;
    end

    // SIMD, FPU emulation and extended physical addressing.
    always_comb begin
        msa  = has_msa & msa_en;
        fre  = frep_impl & fre_en;
        elpa = lpa_impl & elpa_en;
    end
endmodule

// File: rtl/mfg_pamask.sv
// Physical address mask: full PA_BITS ones when extended addressing is
// on, otherwise only the low BASE_BITS bits. Assumes PA_BITS >= BASE_BITS.
module mfg_pamask #(
    parameter int PA_BITS   = 40,
    parameter int BASE_BITS = 32
) (
    input  logic               elpa,
    output logic [PA_BITS-1:0] mask
);
    // One mask bit per address bit; the low bits are always present.
    for (genvar b = 0; b < PA_BITS; b++) begin : g_bit
        if (b < BASE_BITS) begin : g_base
            assign mask[b] = 1'b1;
        end else begin : g_ext
            assign mask[b] = elpa;
        end
    end
endmodule

// File: rtl/mfg_flagreg.sv
// Output register for the flag vector and the address mask. Synchronous,
// active-low reset to the kernel state.
module mfg_flagreg
    import mfg_pkg::*;
#(
    parameter int PA_BITS   = 40,
    parameter int BASE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  mode_flags_t        flags_d,
    input  logic [PA_BITS-1:0] mask_d,
    output mode_flags_t        flags_q,
    output logic [PA_BITS-1:0] mask_q
);
    localparam logic [PA_BITS-1:0] MASK_RST = PA_BITS'({BASE_BITS{1'b1}});

    // Capture the decoded flags each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= FLAGS_RESET;
            mask_q  <= MASK_RST;
        end else begin
            flags_q <= flags_d;
            mask_q  <= mask_d;
        end
    end
endmodule

// File: rtl/mode_flag_gen.sv
// Mode flag generator top. It slices the architectural bits out of the
// source registers, decodes privilege and feature flags and registers them.
// Assumes the register inputs are stable values from the owning registers.
module mode_flag_gen
    import mfg_pkg::*;
#(
    parameter int PA_BITS   = 40,
    parameter int BASE_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        status_i,
    input  logic [31:0]        cfg3_i,
    input  logic [31:0]        cfg5_i,
    input  logic [31:0]        pgrain_i,
    input  logic [31:0]        fpu_impl_i,
    input  logic               debug_mode_i,
    input  logic               mode64_i,
    input  logic               isa_r6_i,
    input  logic               isa_r2_i,
    input  logic               isa_m32_i,
    input  logic               isa_m4_i,
    input  logic               has_dsp_i,
    input  logic               has_dspr2_i,
    input  logic               has_msa_i,
    output logic [1:0]         ksu_o,
    output logic               cp0_ok_o,
    output logic               fpu_ok_o,
    output logic               fpu64_o,
    output logic               rinh_o,
    output logic               dsp_o,
    output logic               dsp2_o,
    output logic               cop1x_o,
    output logic               msa_o,
    output logic               fre_o,
    output logic               elpa_o,
    output logic [PA_BITS-1:0] pa_mask_o
);
    mode_flags_t        flags_d, flags_q;
    logic [PA_BITS-1:0] mask_d, mask_q;
    logic               unused_reg_bits;

    // Only named bits of the source registers matter.
    assign unused_reg_bits = ^{status_i, cfg3_i, cfg5_i, pgrain_i, fpu_impl_i};

    mfg_priv u_priv (
        .ksu_raw (status_i[ST_KSU+1:ST_KSU]),
        .exl     (status_i[ST_EXL]),
        .erl     (status_i[ST_ERL]),
        .dbg     (debug_mode_i),
        .cu0     (status_i[ST_CU0]),
        .isa_r6  (isa_r6_i),
        .sbri_en (cfg5_i[C5_SBRI]),
        .ksu     (flags_d.ksu),
        .cp0_ok  (flags_d.cp0_ok),
        .rinh    (flags_d.rinh)
    );

    mfg_feat u_feat (
        .cu1       (status_i[ST_CU1]),
        .fr        (status_i[ST_FR]),
        .mx        (status_i[ST_MX]),
        .cu3       (status_i[ST_CU3]),
        .f64_impl  (fpu_impl_i[FI_F64]),
        .frep_impl (fpu_impl_i[FI_FREP]),
        .msa_en    (cfg5_i[C5_MSAEN]),
        .fre_en    (cfg5_i[C5_FRE]),
        .lpa_impl  (cfg3_i[C3_LPA]),
        .elpa_en   (pgrain_i[PG_ELPA]),
        .mode64    (mode64_i),
        .isa_r2    (isa_r2_i),
        .isa_m32   (isa_m32_i),
        .isa_m4    (isa_m4_i),
        .has_dsp   (has_dsp_i),
        .has_dspr2 (has_dspr2_i),
        .has_msa   (has_msa_i),
        .fpu_ok    (flags_d.fpu_ok),
        .fpu64     (flags_d.fpu64),
        .dsp       (flags_d.dsp),
        .dsp2      (flags_d.dsp2),
        .cop1x     (flags_d.cop1x),
        .msa       (flags_d.msa),
        .fre       (flags_d.fre),
        .elpa      (flags_d.elpa)
    );

    mfg_pamask #(.PA_BITS(PA_BITS), .BASE_BITS(BASE_BITS)) u_mask (
        .elpa (flags_d.elpa),
        .mask (mask_d)
    );

    mfg_flagreg #(.PA_BITS(PA_BITS), .BASE_BITS(BASE_BITS)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_d (flags_d),
        .mask_d  (mask_d),
        .flags_q (flags_q),
        .mask_q  (mask_q)
    );

    // Drive the ports from the registered flag vector.
    always_comb begin
        ksu_o     = flags_q.ksu;
        cp0_ok_o  = flags_q.cp0_ok;
        fpu_ok_o  = flags_q.fpu_ok;
        fpu64_o   = flags_q.fpu64;
        rinh_o    = flags_q.rinh;
        dsp_o     = flags_q.dsp;
        dsp2_o    = flags_q.dsp2;
        cop1x_o   = flags_q.cop1x;
        msa_o     = flags_q.msa;
        fre_o     = flags_q.fre;
        elpa_o    = flags_q.elpa;
        pa_mask_o = mask_q;
    end
endmodule

// File: rtl/mfg_checker.sv
// Property checker for the mode flag generator, bound to every instance.
// Observes ports only.
module mfg_checker #(
    parameter int PA_BITS   = 40,
    parameter int BASE_BITS = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        status_i,
    input logic [31:0]        fpu_impl_i,
    input logic               debug_mode_i,
    input logic               has_msa_i,
    input logic [1:0]         ksu_o,
    input logic               cp0_ok_o,
    input logic               rinh_o,
    input logic               dsp_o,
    input logic               dsp2_o,
    input logic               msa_o,
    input logic               fre_o,
    input logic               elpa_o,
    input logic [PA_BITS-1:0] pa_mask_o
);
    localparam logic [PA_BITS-1:0] BASE_MASK = PA_BITS'({BASE_BITS{1'b1}});

    a_r1_forced_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i[1] | status_i[2] | debug_mode_i) |=> (ksu_o == 2'b00));

    a_r2_kernel_cp0: assert property (@(posedge clk) disable iff (!rst_n)
        (ksu_o == 2'b00) |-> cp0_ok_o);

    a_r4_rinh_not_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        rinh_o |-> (ksu_o != 2'b00));

    a_r5_dsp2_needs_dsp: assert property (@(posedge clk) disable iff (!rst_n)
        dsp2_o |-> dsp_o);

    a_r7_msa_strap: assert property (@(posedge clk) disable iff (!rst_n)
        !has_msa_i |=> !msa_o);

    a_r8_fre_impl: assert property (@(posedge clk) disable iff (!rst_n)
        !fpu_impl_i[29] |=> !fre_o);

    a_r9_base_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !elpa_o |-> (pa_mask_o == BASE_MASK));
endmodule

bind mode_flag_gen mfg_checker #(.PA_BITS(PA_BITS), .BASE_BITS(BASE_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_i     (status_i),
    .fpu_impl_i   (fpu_impl_i),
    .debug_mode_i (debug_mode_i),
    .has_msa_i    (has_msa_i),
    .ksu_o        (ksu_o),
    .cp0_ok_o     (cp0_ok_o),
    .rinh_o       (rinh_o),
    .dsp_o        (dsp_o),
    .dsp2_o       (dsp2_o),
    .msa_o        (msa_o),
    .fre_o        (fre_o),
    .elpa_o       (elpa_o),
    .pa_mask_o    (pa_mask_o)
);

// File: tb/sim_mode_flag_gen.sv
// Scoreboard bench: the driver pushes model results into a queue and the
// monitor pops one per clock edge and compares it with the outputs.
module sim_mode_flag_gen;
    localparam int PA = 40;
    localparam int OW = 12 + PA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] st = '0, c3 = '0, c5 = '0, pg = '0, fi = '0;
    logic dbg = 1'b0, m64 = 1'b0;
    logic [6:0] sp = '0;
    logic [1:0] ksu;
    logic cp0, fpu, f64, rinh, dsp, dsp2, cop1x, msa, fre, elpa;
    logic [PA-1:0] mask;
    logic [OW-1:0] exp_q[$];
    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mode_flag_gen #(.PA_BITS(PA)) u0 (
        .clk(clk), .rst_n(rst_n), .status_i(st), .cfg3_i(c3), .cfg5_i(c5),
        .pgrain_i(pg), .fpu_impl_i(fi), .debug_mode_i(dbg), .mode64_i(m64),
        .isa_r6_i(sp[6]), .isa_r2_i(sp[5]), .isa_m32_i(sp[4]), .isa_m4_i(sp[3]),
        .has_dsp_i(sp[2]), .has_dspr2_i(sp[1]), .has_msa_i(sp[0]),
        .ksu_o(ksu), .cp0_ok_o(cp0), .fpu_ok_o(fpu), .fpu64_o(f64), .rinh_o(rinh),
        .dsp_o(dsp), .dsp2_o(dsp2), .cop1x_o(cop1x), .msa_o(msa), .fre_o(fre),
        .elpa_o(elpa), .pa_mask_o(mask)
    );

    function automatic logic [OW-1:0] reset_exp();
        return {2'b00, 1'b1, 9'b0, PA'({32{1'b1}})};
    endfunction

    // Independent model of the requirements.
    function automatic logic [OW-1:0] model();
        logic [1:0] k;
        logic e;
        k = (st[1] | st[2] | dbg) ? 2'b00 : st[4:3];
        e = c3[7] & pg[29];
        return {k,
                (k == 2'b00) | (st[28] & ~sp[6]),
                st[29], st[26],
                (k != 2'b00) & c5[6],
                (sp[1] | sp[2]) & st[24],
                sp[1] & st[24],
                sp[5] ? fi[22] : sp[4] ? m64 : sp[3] ? st[31] : 1'b0,
                sp[0] & c5[27],
                fi[29] & c5[8],
                e,
                e ? {PA{1'b1}} : PA'({32{1'b1}})};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, expv);
        end
    endtask

    function automatic logic [OW-1:0] actual();
        return {ksu, cp0, fpu, f64, rinh, dsp, dsp2, cop1x, msa, fre, elpa, mask};
    endfunction

    task automatic drive(logic [31:0] s, logic [31:0] a3, logic [31:0] a5,
                         logic [31:0] g, logic [31:0] f, logic d, logic w,
                         logic [6:0] straps);
        @(negedge clk);
        rst_n = 1'b1;
        st = s; c3 = a3; c5 = a5; pg = g; fi = f; dbg = d; m64 = w; sp = straps;
        exp_q.push_back(model());
    endtask

    // Monitor: compare each queued expectation just after its edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [OW-1:0] e, a;
            e = exp_q.pop_front();
            a = actual();
            check("R1 ksu",   64'(a[OW-1:OW-2]), 64'(e[OW-1:OW-2]));
            check("R2 cp0",   64'(a[OW-3]), 64'(e[OW-3]));
            check("R3 fpu",   64'(a[OW-4:OW-5]), 64'(e[OW-4:OW-5]));
            check("R4 rinh",  64'(a[OW-6]), 64'(e[OW-6]));
            check("R5 dsp",   64'(a[OW-7:OW-8]), 64'(e[OW-7:OW-8]));
            check("R6 cop1x", 64'(a[OW-9]), 64'(e[OW-9]));
            check("R7 msa",   64'(a[OW-10]), 64'(e[OW-10]));
            check("R8 fre",   64'(a[OW-11]), 64'(e[OW-11]));
            check("R9 elpa/mask", 64'(a[PA:0]), 64'(e[PA:0]));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got %0d expected <100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R11 reset state", 64'(actual()), 64'(reset_exp()));
        // R1: user, supervisor, and each forcing source
        drive(32'h0000_0010, 0, 0, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0008, 0, 0, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0012, 0, 0, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0014, 0, 0, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0010, 0, 0, 0, 0, 1, 0, 7'b0);
        // R10: change input at negedge; output holds until the edge
        drive(32'h0000_0010, 0, 0, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0012, 0, 0, 0, 0, 0, 0, 7'b0);
        #1 check("R10 latency", 64'(ksu), 64'(2'b10));
        // R2: cu0 with and without release 6
        drive(32'h1000_0010, 0, 0, 0, 0, 0, 0, 7'b0000000);
        drive(32'h1000_0010, 0, 0, 0, 0, 0, 0, 7'b1000000);
        // R3, R4
        drive(32'h2400_0008, 0, 32'h40, 0, 0, 0, 0, 7'b0);
        drive(32'h0000_0000, 0, 32'h40, 0, 0, 0, 0, 7'b0);
        // R5: each DSP strap combination
        drive(32'h0100_0000, 0, 0, 0, 0, 0, 0, 7'b0000010);
        drive(32'h0100_0000, 0, 0, 0, 0, 0, 0, 7'b0000100);
        drive(32'h0100_0000, 0, 0, 0, 0, 0, 0, 7'b0000000);
        // R6: priority levels
        drive(32'h8000_0000, 0, 0, 0, 32'h0040_0000, 0, 1, 7'b0111000);
        drive(32'h8000_0000, 0, 0, 0, 32'h0000_0000, 0, 1, 7'b0111000);
        drive(32'h8000_0000, 0, 0, 0, 0, 0, 0, 7'b0011000);
        drive(32'h8000_0000, 0, 0, 0, 0, 0, 0, 7'b0001000);
        // R7, R8, R9
        drive(0, 0, 32'h0800_0000, 0, 0, 0, 0, 7'b0000001);
        drive(0, 0, 32'h0800_0100, 0, 32'h2000_0000, 0, 0, 7'b0);
        drive(0, 32'h80, 0, 32'h2000_0000, 0, 0, 0, 7'b0);
        drive(0, 32'h80, 0, 0, 0, 0, 0, 7'b0);
        // R11: reset mid-run
        drive(32'hFFFF_FFF8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
              32'hFFFF_FFFF, 0, 1, 7'b0111111);
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.push_back(reset_exp());
        // Random sweep
        for (int i = 0; i < 400; i++) begin
            drive($urandom, $urandom, $urandom, $urandom, $urandom,
                  1'($urandom_range(0, 3) == 0), 1'($urandom), 7'($urandom));
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule